// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block sits between a serial line receiver and the host-facing read path. It buffers received characters in an eight-entry first-in first-out queue. Each entry carries three error flags: parity error, framing error and break. The host reads the oldest character at the head. It reads status without side effects and pops with a separate read strobe.

Status is reported in one of two views. The per-character view shows only the head entry's flags. The accumulated view shows the OR of the flags of every character that has reached the head since the last error-clear command. When the queue is full, one further character waits in a holding stage and enters the queue as soon as an entry frees. If a new character starts while that stage is still occupied, the held character is lost and a sticky overrun flag is raised.

Top module: `rx_char_queue`

## Requirements
- R1: The queue returns up to eight characters in arrival order. `head_data_o` shows the oldest queued character, and is zero while the queue is empty.
- R2: `ready_o` is high whenever at least one character is queued. `full_o` is high exactly when all eight entries are occupied. Both change in the cycle after the load or pop edge.
- R3: `level_o` equals the number of occupied entries for 0 to 7 entries, and reads 7 when eight entries are occupied.
- R4: With `blk_mode_i` low, `err_o` shows the status of the head character (bit 0 parity, bit 1 framing, bit 2 break), and is zero while the queue is empty.
- R5: With `blk_mode_i` high, `err_o` is the OR of the status of every character that has been at the head since the last `clr_err_i` pulse, including the current head. `clr_err_i` empties this accumulation.
- R6: Observing status or data changes nothing. Only `pop_i` removes the head, and `pop_i` on an empty queue has no effect.
- R7: A character loaded while the queue is full and not being popped is kept in a holding stage. It enters the queue, behind all earlier characters, on the first cycle a pop frees an entry.
- R8: A `start_i` pulse while the holding stage is occupied and no pop frees an entry sets `overrun_o` in the next cycle. The next loaded character replaces the held one, and the queued entries are unchanged. A `start_i` pulse with the holding stage empty does not set `overrun_o`.
- R9: `overrun_o` stays set until a `clr_err_i` pulse clears it. If a new overrun occurs in the same cycle as the clear, the flag stays set.
- R10: A load and a pop in the same cycle leave the level unchanged and keep arrival order.
- R11: After reset the queue is empty: `ready_o`, `full_o`, `level_o`, `err_o` and `overrun_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Strobe: a received character is presented |
| data_i | input | DATA_W | Received character |
| stat_i | input | 3 | Status of the received character: {break, framing, parity} |
| start_i | input | 1 | Pulse: a new start bit was detected |
| pop_i | input | 1 | Read strobe, removes the head entry |
| clr_err_i | input | 1 | Error-clear command |
| blk_mode_i | input | 1 | 1 = accumulated error view, 0 = per-character view |
| head_data_o | output | DATA_W | Character at the head of the queue |
| err_o | output | 3 | Reported error flags {break, framing, parity} |
| ready_o | output | 1 | At least one character queued |
| full_o | output | 1 | All eight entries occupied |
| level_o | output | 3 | Occupancy, saturating at 7 |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The assertions check these properties on every cycle:
- full implies ready with a level of 7;
- the holding stage is occupied only while the queue is full;
- overrun rises after a start pulse that meets an occupied holding stage, then stays set until a clear removes it;
- the accumulated error view never loses a bit without a clear;
- a load paired with a pop keeps the level;
- a pop on an empty queue leaves it empty.

Only the bench scenarios can show the following:
- that characters leave in arrival order with their own status;
- that the held character lands last after the queue drains;
- that an overrun replaces the held character while the eight queued ones survive;
- the exact accumulated bit patterns across pops.

// File: rtl/rcq_pkg.sv
package rcq_pkg;
  localparam int unsigned STAT_W = 3;
  localparam int unsigned ST_PAR = 0;
  localparam int unsigned ST_FRM = 1;
  localparam int unsigned ST_BRK = 2;
endpackage

// File: rtl/rcq_store.sv
module rcq_store #(
  parameter int unsigned E_W   = 11,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [E_W-1:0]   wdata_i,
  input  logic             pop_i,
  output logic [E_W-1:0]   rdata_o,
  output logic [CNT_W-1:0] count_o
);
  logic [E_W-1:0]   mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      unique case ({push_i, pop_i})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_q];
endmodule

// File: rtl/rcq_hold.sv
module rcq_hold #(
  parameter int unsigned E_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [E_W-1:0] wdata_i,
  input  logic           start_i,
  input  logic           space_i,
  input  logic           clr_i,
  output logic           push_o,
  output logic [E_W-1:0] push_data_o,
  output logic           hold_v_o,
  output logic           ovr_o
);
  logic [E_W-1:0] hold_q;
  logic           move, direct, ovr_set;

  assign move        = hold_v_o && space_i;
  assign direct      = load_i && !hold_v_o && space_i;
  assign push_o      = move || direct;
  assign push_data_o = hold_v_o ? hold_q : wdata_i;
  assign ovr_set     = start_i && hold_v_o && !space_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_o <= 1'b0;
      hold_q   <= '0;
      ovr_o    <= 1'b0;
    end else begin
      // A load that cannot go straight in takes the stage, displacing any stuck entry
      if (load_i && !direct) begin
        hold_v_o <= 1'b1;
        hold_q   <= wdata_i;
      end else if (move) begin
        hold_v_o <= 1'b0;
      end
      if (ovr_set)    ovr_o <= 1'b1;
      else if (clr_i) ovr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rcq_errview.sv
module rcq_errview
  import rcq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_mode_i,
  input  logic              clr_i,
  input  logic              ready_i,
  input  logic [STAT_W-1:0] head_stat_i,
  output logic [STAT_W-1:0] err_o
);
  logic [STAT_W-1:0] acc_q, head_vis;

  assign head_vis = ready_i ? head_stat_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= acc_q | head_vis;
  end

  assign err_o = blk_mode_i ? (acc_q | head_vis) : head_vis;
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rcq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned E_W   = DATA_W + STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              start_i,
  input  logic              pop_i,
  input  logic              clr_err_i,
  input  logic              blk_mode_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic [STAT_W-1:0] err_o,
  output logic              ready_o,
  output logic              full_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              overrun_o
);
  logic [CNT_W-1:0] q_count;
  logic [E_W-1:0]   rdata, push_data;
  logic             pop_eff, space, push, hold_v;

  assign ready_o = (q_count != '0);
  assign full_o  = (q_count == CNT_W'(DEPTH));
  assign pop_eff = pop_i && ready_o;
  assign space   = !full_o || pop_eff;
  assign level_o = full_o ? LVL_W'(DEPTH - 1) : q_count[LVL_W-1:0];

  rcq_hold #(.E_W(E_W)) hold_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .wdata_i    ({stat_i, data_i}),
    .start_i    (start_i),
    .space_i    (space),
    .clr_i      (clr_err_i),
    .push_o     (push),
    .push_data_o(push_data),
    .hold_v_o   (hold_v),
    .ovr_o      (overrun_o)
  );

  rcq_store #(.E_W(E_W), .DEPTH(DEPTH)) store_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .wdata_i(push_data),
    .pop_i  (pop_eff),
    .rdata_o(rdata),
    .count_o(q_count)
  );

  rcq_errview errview_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blk_mode_i (blk_mode_i),
    .clr_i      (clr_err_i),
    .ready_i    (ready_o),
    .head_stat_i(rdata[E_W-1:DATA_W]),
    .err_o      (err_o)
  );

  assign head_data_o = ready_o ? rdata[DATA_W-1:0] : '0;
endmodule

// File: rtl/rcq_chk.sv
module rcq_chk #(
  parameter int unsigned LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             start_i,
  input logic             pop_i,
  input logic             clr_err_i,
  input logic             blk_mode_i,
  input logic [2:0]       err_o,
  input logic             ready_o,
  input logic             full_o,
  input logic [LVL_W-1:0] level_o,
  input logic             overrun_o,
  input logic             hold_v
);
  assert_full_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> ready_o);
  assert_full_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (level_o == {LVL_W{1'b1}}));
  assert_char_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk_mode_i && !ready_o) |-> (err_o == 3'b000));
  assert_blk_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_mode_i && !clr_err_i) |=> (!blk_mode_i || ((err_o & $past(err_o)) == $past(err_o))));
  assert_empty_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !load_i) |=> !ready_o);
  assert_hold_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_v |-> full_o);
  assert_ovr_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && hold_v && !pop_i) |=> overrun_o);
  assert_ovr_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clr_err_i) |=> overrun_o);
  assert_ovr_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && !(start_i && hold_v && !pop_i)) |=> !overrun_o);
  assert_same_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !full_o && load_i && pop_i) |=> ($stable(level_o) && !full_o));
endmodule

bind rx_char_queue rcq_chk #(.LVL_W(LVL_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .start_i   (start_i),
  .pop_i     (pop_i),
  .clr_err_i (clr_err_i),
  .blk_mode_i(blk_mode_i),
  .err_o     (err_o),
  .ready_o   (ready_o),
  .full_o    (full_o),
  .level_o   (level_o),
  .overrun_o (overrun_o),
  .hold_v    (hold_v)
);

// File: tb/rx_char_queue_tb.sv
module rx_char_queue_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 0, start_i = 0, pop_i = 0, clr_err_i = 0, blk_mode_i = 0;
  logic [7:0] data_i = '0;
  logic [2:0] stat_i = '0;
  logic [7:0] head_data_o;
  logic [2:0] err_o, level_o;
  logic       ready_o, full_o, overrun_o;
  int         n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  rx_char_queue dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .data_i(data_i), .stat_i(stat_i),
    .start_i(start_i), .pop_i(pop_i), .clr_err_i(clr_err_i), .blk_mode_i(blk_mode_i),
    .head_data_o(head_data_o), .err_o(err_o), .ready_o(ready_o), .full_o(full_o),
    .level_o(level_o), .overrun_o(overrun_o)
  );

  function automatic logic [7:0] dv(input int i);
    return 8'((i * 29 + 3) % 256);
  endfunction
  function automatic logic [2:0] sv(input int i);
    return 3'((i * 5 + 1) % 8);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the following posedge
  task automatic cyc(input logic l, input logic [7:0] d, input logic [2:0] s,
                     input logic st, input logic p, input logic c);
    @(negedge clk_i);
    load_i = l; data_i = d; stat_i = s; start_i = st; pop_i = p; clr_err_i = c;
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle();
    cyc(0, 8'h00, 3'b000, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R11 ready", ready_o, 0); check("R11 full", full_o, 0);
    check("R11 level", level_o, 0); check("R11 err", err_o, 0);
    check("R11 overrun", overrun_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // sweep fill 1..8 with start pulses on an empty holding stage
    for (int i = 0; i < 8; i++) begin
      cyc(1, dv(i), sv(i), 1, 0, 0);
      check("R3 level", level_o, (i + 1 > 7) ? 7 : i + 1);
      check("R2 full", full_o, (i == 7) ? 1 : 0);
      check("R2 ready", ready_o, 1);
    end
    check("R8 no overrun", overrun_o, 0);

    // drain, checking order and per-character status
    for (int i = 0; i < 8; i++) begin
      check("R1 head", head_data_o, dv(i));
      check("R4 err", err_o, sv(i));
      cyc(0, 8'h00, 3'b000, 0, 1, 0);
      check("R3 level drain", level_o, 7 - i);
    end
    check("R2 empty", ready_o, 0);
    check("R1 zero head", head_data_o, 0);
    check("R4 empty err", err_o, 0);

    // pop on empty, status observation has no effect
    cyc(0, 8'h00, 3'b000, 0, 1, 0);
    check("R6 empty pop", ready_o, 0);
    check("R6 empty pop level", level_o, 0);
    cyc(1, 8'h5A, 3'b100, 0, 0, 0);
    idle(); idle(); idle();
    check("R6 head kept", head_data_o, 8'h5A);
    check("R6 level kept", level_o, 1);
    cyc(0, 8'h00, 3'b000, 0, 1, 0);

    // accumulated view
    cyc(0, 8'h00, 3'b000, 0, 0, 1);
    blk_mode_i = 1'b1;
    idle();
    check("R5 cleared", err_o, 0);
    cyc(1, 8'h11, 3'b001, 0, 0, 0);
    check("R5 first", err_o, 1);
    cyc(1, 8'h22, 3'b010, 0, 0, 0);
    check("R5 second queued", err_o, 1);
    cyc(0, 8'h00, 3'b000, 0, 1, 0);
    check("R5 or", err_o, 3);
    cyc(0, 8'h00, 3'b000, 0, 1, 0);
    check("R5 kept empty", err_o, 3);
    cyc(0, 8'h00, 3'b000, 0, 0, 1);
    check("R5 clear", err_o, 0);
    blk_mode_i = 1'b0;

    // simultaneous load and pop
    for (int i = 0; i < 3; i++) cyc(1, dv(20 + i), 3'b000, 0, 0, 0);
    cyc(1, dv(23), 3'b000, 0, 1, 0);
    check("R10 level", level_o, 3);
    for (int i = 1; i < 4; i++) begin
      check("R10 order", head_data_o, dv(20 + i));
      cyc(0, 8'h00, 3'b000, 0, 1, 0);
    end
    check("R10 drained", ready_o, 0);

    // holding stage
    for (int i = 0; i < 8; i++) cyc(1, dv(40 + i), 3'b000, 0, 0, 0);
    cyc(1, 8'hC3, 3'b000, 1, 0, 0);
    check("R7 full", full_o, 1);
    check("R7 head", head_data_o, dv(40));
    check("R8 no overrun held", overrun_o, 0);
    for (int i = 0; i < 9; i++) begin
      check("R7 order", head_data_o, (i < 8) ? dv(40 + i) : 8'hC3);
      cyc(0, 8'h00, 3'b000, 0, 1, 0);
      if (i == 0) check("R7 refilled", full_o, 1);
    end
    check("R7 drained", ready_o, 0);

    // overrun
    for (int i = 0; i < 8; i++) cyc(1, dv(60 + i), 3'b000, 0, 0, 0);
    cyc(1, 8'hA1, 3'b000, 0, 0, 0);
    cyc(0, 8'h00, 3'b000, 1, 0, 0);
    check("R8 overrun", overrun_o, 1);
    cyc(1, 8'hB2, 3'b000, 0, 0, 0);
    check("R8 level", level_o, 7);
    check("R8 head", head_data_o, dv(60));
    for (int i = 0; i < 9; i++) begin
      check("R8 order", head_data_o, (i < 8) ? dv(60 + i) : 8'hB2);
      cyc(0, 8'h00, 3'b000, 0, 1, 0);
    end
    check("R8 drained", ready_o, 0);
    check("R9 sticky", overrun_o, 1);
    cyc(0, 8'h00, 3'b000, 0, 0, 1);
    check("R9 cleared", overrun_o, 0);

    // clear and new overrun together: set wins
    for (int i = 0; i < 9; i++) cyc(1, dv(i), 3'b000, 0, 0, 0);
    cyc(0, 8'h00, 3'b000, 1, 0, 1);
    check("R9 set wins", overrun_o, 1);

    finish_run();
  end
endmodule